// File: doc/BRIEF.md
# Continuous-Wave Channel Clock Generator

This block produces the gate-control signals for one transmit channel of an ultrasound pulser. It has two modes. In continuous-wave mode, a programmable divider counts transmit clocks. Every time the count completes, a toggle stage flips. The P and N gate controls follow that toggle in complementary fashion, so the output swings at a fixed frequency with a 50% duty cycle. In pattern mode, the block decodes the channel's current P and N pattern bits into gate controls. That decode includes the return-to-zero state and the state that prevents cross-conduction.

A 6-bit divider value sets the half-period N in transmit clocks. The full continuous-wave period is 2N clocks. A channel whose delay code is all ones is held fully off in continuous-wave mode. In that mode the block also withholds the shift permission from the pattern registers, so they stay frozen. A low enable turns everything off. The serial loading of the pattern and delay registers is done elsewhere, and so are the analog drivers.

Top module: `cw_chan_clkgen`

## Requirements
- R1: The divider value `div_sel` encodes the half-period N in transmit clocks. Zero means N=64, and values 1 to 63 mean N directly. A continuous-wave period is 2N clocks.
- R2: While continuous-wave mode runs, `p_on` is high for exactly N consecutive cycles and `n_on` is high for the next N, repeating.
- R3: On the first cycle of continuous-wave mode (enable and mode both high after either was low), the first half-period drives `p_on` high.
- R4: In continuous-wave mode with a delay code that is not all ones, exactly one of `p_on` and `n_on` is high, and `rtz` is low.
- R5: In continuous-wave mode with a delay code of all ones, `p_on`, `n_on` and `rtz` are all low.
- R6: `shift_ok` is high only when enable is high and continuous-wave mode is low. It is low in continuous-wave mode, which freezes the pattern registers.
- R7: A low `en` drives `p_on`, `n_on`, `rtz` and `shift_ok` low, whatever the other inputs are.
- R8: A change of `div_sel` during continuous-wave operation does not alter the current half-period. It takes effect from the half-period that begins after the next terminal count.
- R9: In pattern mode with enable high, the pattern bits decode as follows:
  - `pat_p`=1 and `pat_n`=0 gives `p_on`.
  - `pat_p`=0 and `pat_n`=1 gives `n_on`.
  - Both bits low gives `rtz`.
  - Both bits high leaves all three outputs low.
- R10: All outputs are registered and reflect the inputs one rising clock edge later. A synchronous reset clears all four outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable |
| cw_mode | input | 1 | Selects continuous-wave mode when high |
| div_sel | input | 6 | Half-period code (0 means 64) |
| dly_code | input | 10 | Channel delay register; all ones disables the channel in continuous-wave mode |
| pat_p | input | 1 | Current P pattern bit |
| pat_n | input | 1 | Current N pattern bit |
| p_on | output | 1 | P gate on |
| n_on | output | 1 | N gate on |
| rtz | output | 1 | Return-to-zero switch on |
| shift_ok | output | 1 | Pattern registers may shift |

## Verification
Every output is due one rising edge after the inputs that cause it. Inputs change only on falling edges, and outputs are compared on the next falling edge against a cycle model that the bench advances on the same rising edge. The bench expects a continuous-wave transition N edges after the previous one, counted from the first running edge. It also expects a new divider value to apply only from the edge after a terminal count. Directed runs measure the high-time of `p_on` and `n_on` in cycles. They check a full 64-cycle half-period, the first half after entry, and a divider change made mid-half.

// File: rtl/cwgen_pkg.sv
// Shared types for the continuous-wave channel clock generator.
package cwgen_pkg;
    // Which gate control a channel drives in a given cycle.
    typedef enum logic [1:0] {
        DRV_OFF = 2'd0,
        DRV_P   = 2'd1,
        DRV_N   = 2'd2,
        DRV_RTZ = 2'd3
    } drive_e;
endpackage

// File: rtl/cwgen_divider.sv
// Programmable divide-by-N for the continuous-wave clock.
// Emits a one-cycle tick every N cycles while run is high. N is latched
// at the terminal count (or while idle), so a new divider value never
// shortens or stretches the half-period in progress.
// Assumes: div_sel of zero means N = 2**DIV_W.
module cwgen_divider #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int NW = DIV_W + 1;
    localparam logic [NW-1:0] N_MAX = NW'(1) << DIV_W;

    logic [NW-1:0]    n_req;
    logic [NW-1:0]    n_act;
    logic [DIV_W-1:0] cnt;
    logic [NW-1:0]    cnt_ext;

    // Decode the divider code into the half-period length.
    always_comb begin
        n_req   = (div_sel == '0) ? N_MAX : {1'b0, div_sel};
        cnt_ext = {1'b0, cnt};
        tick    = run && (cnt_ext == n_act - NW'(1));
    end

    // Count within a half-period; reload N only at terminal count or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            n_act <= N_MAX;
        end else if (!run) begin
            cnt   <= '0;
            n_act <= n_req;
        end else if (tick) begin
            cnt   <= '0;
            n_act <= n_req;
        end else begin
            cnt   <= cnt + DIV_W'(1);
        end
    end

    p_cnt_below_n_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ext < n_act);
    p_hold_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(n_act));
endmodule

// File: rtl/cwgen_halver.sv
// Divide-by-2 toggle stage fed by the divider tick.
// Produces the 50% duty-cycle phase. The phase rests at 1 while idle, so
// the first half-period after entry drives the P side.
module cwgen_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic phase
);
    // Flip the phase on each tick; park at 1 while not running.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= 1'b1;
        else if (!run)  phase <= 1'b1;
        else if (tick)  phase <= ~phase;
    end

    p_phase_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(phase));
    p_entry_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> phase);
endmodule

// File: rtl/cwgen_drive_sel.sv
// Chooses the channel's gate drive and registers the outputs.
// Priority: disable, then continuous-wave (with the all-ones delay kill),
// then the pattern-bit decode. Pattern shifting is allowed only in pattern
// mode with the channel enabled.
module cwgen_drive_sel
    import cwgen_pkg::*;
#(
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cw_mode,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             phase,
    input  logic             pat_p,
    input  logic             pat_n,
    output logic             p_on,
    output logic             n_on,
    output logic             rtz,
    output logic             shift_ok
);
    drive_e sel;

    // Select the drive for the coming cycle.
    always_comb begin
        if (!en) begin
            sel = DRV_OFF;
        end else if (cw_mode) begin
            if (&dly_code) sel = DRV_OFF;
            else           sel = phase ? DRV_P : DRV_N;
        end else begin
            case ({pat_p, pat_n})
                2'b10:   sel = DRV_P;
                2'b01:   sel = DRV_N;
                2'b00:   sel = DRV_RTZ;
                default: sel = DRV_OFF;
            endcase
        end
    end

    // Register the gate controls and the shift permission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_on     <= 1'b0;
            n_on     <= 1'b0;
            rtz      <= 1'b0;
            shift_ok <= 1'b0;
        end else begin
            p_on     <= (sel == DRV_P);
            n_on     <= (sel == DRV_N);
            rtz      <= (sel == DRV_RTZ);
            shift_ok <= en && !cw_mode;
        end
    end

    p_one_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({p_on, n_on, rtz}));
    p_off_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!p_on && !n_on && !rtz && !shift_ok));
    p_cw_swing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cw_mode && !(&dly_code)) |=> ((p_on != n_on) && !rtz));
    p_cw_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cw_mode && (&dly_code)) |=> (!p_on && !n_on && !rtz));
    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cw_mode |=> !shift_ok);
endmodule

// File: rtl/cw_chan_clkgen.sv
// Continuous-wave channel clock generator, top level.
// Divider -> toggle stage -> drive selector. Continuous-wave operation runs
// while both en and cw_mode are high; leaving it resets divider and toggle.
// Assumes: all inputs are synchronous to clk.
module cw_chan_clkgen #(
    parameter int DIV_W = 6,
    parameter int DLY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cw_mode,
    input  logic [DIV_W-1:0] div_sel,
    input  logic [DLY_W-1:0] dly_code,
    input  logic             pat_p,
    input  logic             pat_n,
    output logic             p_on,
    output logic             n_on,
    output logic             rtz,
    output logic             shift_ok
);
    logic run;
    logic tick;
    logic phase;

    // Continuous-wave operation needs both enable and mode.
    always_comb run = en && cw_mode;

    cwgen_divider #(.DIV_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
    );

    cwgen_halver i_half (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .phase(phase)
    );

    cwgen_drive_sel #(.DLY_W(DLY_W)) i_sel (
        .clk(clk), .rst_n(rst_n), .en(en), .cw_mode(cw_mode),
        .dly_code(dly_code), .phase(phase), .pat_p(pat_p), .pat_n(pat_n),
        .p_on(p_on), .n_on(n_on), .rtz(rtz), .shift_ok(shift_ok)
    );
endmodule

// File: tb/test_cw_chan_clkgen.sv
`timescale 1ns/1ps
module test_cw_chan_clkgen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cw_mode = 1'b0;
    logic [5:0] div_sel = 6'd0;
    logic [9:0] dly_code = 10'd0;
    logic       pat_p = 1'b0;
    logic       pat_n = 1'b0;
    logic       p_on, n_on, rtz, shift_ok;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cw_chan_clkgen i_cw_chan_clkgen (
        .clk(clk), .rst_n(rst_n), .en(en), .cw_mode(cw_mode),
        .div_sel(div_sel), .dly_code(dly_code), .pat_p(pat_p), .pat_n(pat_n),
        .p_on(p_on), .n_on(n_on), .rtz(rtz), .shift_ok(shift_ok)
    );

    // Half-period from the divider code (R1).
    function automatic int half_len(input logic [5:0] code);
        return (code == 6'd0) ? 64 : int'(code);
    endfunction

    // Cycle model, advanced on each rising edge.
    logic [2:0] exp_drv = 3'b000;
    logic       exp_shift = 1'b0;
    string      exp_tag = "R10";
    bit         m_phase = 1'b1;
    int         m_pos = 0;
    int         m_n = 64;

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_drv = 3'b000; exp_shift = 1'b0; exp_tag = "R10";
            m_phase = 1'b1; m_pos = 0; m_n = 64;
        end else begin
            if (!en) begin
                exp_drv = 3'b000; exp_tag = "R7";
            end else if (cw_mode) begin
                if (dly_code == 10'h3FF) begin
                    exp_drv = 3'b000; exp_tag = "R5";
                end else begin
                    exp_drv = m_phase ? 3'b100 : 3'b010; exp_tag = "R4/R2";
                end
            end else begin
                exp_tag = "R9";
                case ({pat_p, pat_n})
                    2'b10:   exp_drv = 3'b100;
                    2'b01:   exp_drv = 3'b010;
                    2'b00:   exp_drv = 3'b001;
                    default: exp_drv = 3'b000;
                endcase
            end
            exp_shift = en && !cw_mode;
            if (!(en && cw_mode)) begin
                m_phase = 1'b1; m_pos = 0; m_n = half_len(div_sel);
            end else if (m_pos == m_n - 1) begin
                m_pos = 0; m_phase = !m_phase; m_n = half_len(div_sel);
            end else begin
                m_pos++;
            end
        end
    end

    task automatic check(input string tag, input int got, input int expv);
        n_checks++;
        if (got != expv) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, expv, $time);
        end
    endtask

    // One rising edge, then compare at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check(exp_tag, int'({p_on, n_on, rtz}), int'(exp_drv));
        check("R6", int'(shift_ok), int'(exp_shift));
    endtask

    // Count the cycles for which the given side stays on, starting now.
    task automatic count_run(input bit want_p, output int len);
        len = 0;
        while (p_on == want_p && n_on == !want_p && len < 500) begin
            len++;
            step();
        end
    endtask

    int len;

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R10 reset", int'({p_on, n_on, rtz, shift_ok}), 0);
        rst_n = 1'b1;
        step();

        // R7: disabled with patterns toggling
        for (int i = 0; i < 8; i++) begin
            pat_p = i[0]; pat_n = i[1]; cw_mode = i[2];
            step();
        end

        // R9: each pattern code in pattern mode
        en = 1'b1; cw_mode = 1'b0;
        for (int i = 0; i < 4; i++) begin
            {pat_p, pat_n} = i[1:0];
            step();
        end

        // R3 and R1: entry with code 0 gives 64-cycle halves, P first
        div_sel = 6'd0; step();
        cw_mode = 1'b1; step();
        check("R3 first half P", int'(p_on), 1);
        count_run(1'b1, len); check("R1 P half 64", len, 64);
        count_run(1'b0, len); check("R1 N half 64", len, 64);

        // R8: divider change mid-half applies only after terminal count
        cw_mode = 1'b0; div_sel = 6'd4; step(); step();
        cw_mode = 1'b1; step(); step();
        div_sel = 6'd2;
        count_run(1'b1, len); check("R8 old half kept", len, 3);
        count_run(1'b0, len); check("R8 new half", len, 2);
        count_run(1'b1, len); check("R2 next half", len, 2);

        // R1: code 1 alternates every cycle
        cw_mode = 1'b0; div_sel = 6'd1; step();
        cw_mode = 1'b1; step();
        count_run(1'b1, len); check("R1 N=1 P", len, 1);
        count_run(1'b0, len); check("R1 N=1 N", len, 1);

        // R5: all-ones delay kills the channel
        dly_code = 10'h3FF; repeat (6) step();
        dly_code = 10'h000;

        // Random segments
        for (int s = 0; s < 80; s++) begin
            int seg_len = $urandom_range(10, 200);
            int chg_at  = $urandom_range(0, seg_len);
            en       = ($urandom_range(0, 9) != 0);
            cw_mode  = ($urandom_range(0, 9) < 7);
            div_sel  = ($urandom_range(0, 1) != 0) ? 6'($urandom_range(0, 7)) : 6'($urandom);
            dly_code = ($urandom_range(0, 6) == 0) ? 10'h3FF : 10'($urandom);
            for (int c = 0; c < seg_len; c++) begin
                if (c == chg_at && $urandom_range(0, 2) == 0)
                    div_sel = 6'($urandom_range(0, 9));
                pat_p = 1'($urandom); pat_n = 1'($urandom);
                step();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule